// File: doc/BRIEF.md
# Randomized Core Clock Enable Generator

This block runs on one fast external clock and produces a core clock enable that fires on unpredictable cycles. Software attacks that time a fault or a measurement to a fixed cycle count after reset then lose their reference point. A digital noise bit is folded into the feedback of a 16-bit maximal-length shift register. The register's newest bit is the smoothed random decision for each cycle. An internal phase bit flips whenever that decision is 1, and the core enable pulses on each 0-to-1 transition of the phase. The core therefore advances about once every four external cycles on average.

On every active cycle in which the core does not advance, the block raises a dummy strobe and drives pseudo-random filler data, so that idle gaps look like normal switching. Peripherals that need exact timing, such as a serial port or a timer, get a separate enable that is high on every external cycle once reset has been released. A 16-bit counter of issued core enables is brought out so that the rate can be checked.

Top module: `rnd_clk_gen`

## Requirements
- R1: While reset (`rst_n` low) is applied, `core_en_o`, `dummy_o`, `periph_en_o`, `dummy_data_o` and `core_count_o` are all zero.
- R2: From the first clock edge after reset is released, `periph_en_o` is 1 on every cycle.
- R3: `core_en_o` is a single-cycle pulse and is never high on two consecutive cycles.
- R4: Over 1000 consecutive external cycles after reset, the number of cycles with `core_en_o` high lies between 200 and 300 inclusive, for a noise input held at 0, held at 1, or alternating.
- R5: `core_count_o` equals the number of earlier cycles since reset on which `core_en_o` was high, modulo 2^16.
- R6: After reset is released, `dummy_o` is 1 exactly on the cycles where `core_en_o` is 0, and the two are never high together.
- R7: `dummy_data_o` is zero whenever `dummy_o` is 0, and it takes more than one distinct value across the dummy cycles of a 1000-cycle run.
- R8: The noise input enters the random decision. Two runs from reset, one with the noise held at 0 and one with it held at 1, produce different `core_en_o` patterns within their first 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast external clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| noise_i | input | 1 | Raw digital noise bit |
| core_en_o | output | 1 | Randomized core clock enable |
| dummy_o | output | 1 | Dummy-activity strobe for cycles without a core enable |
| dummy_data_o | output | 8 | Filler data driven during dummy cycles |
| periph_en_o | output | 1 | Fixed-rate enable for timing-critical peripherals |
| core_count_o | output | 16 | Number of core enables issued since reset |

## Verification
The assertions assume that `noise_i` is a clean digital level that is stable around the clock edge, and that `rst_n` is released only at a time with no edge nearby. They make no assumption about the statistics of the noise. The bench changes `noise_i` only at the falling edge, using three fixed patterns: constant low, constant high and alternating. It releases reset at a falling edge, so every sampled value comes from a well-defined cycle.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    localparam int LFSR_W = 16;
    typedef logic [LFSR_W-1:0] lfsr_t;
    // feedback taps for x^16 + x^14 + x^13 + x^11 + 1 (bits 15,13,12,10)
    localparam lfsr_t TAP_MASK = 16'hB400;
endpackage

// File: rtl/rcg_lfsr.sv
module rcg_lfsr
    import rcg_pkg::*;
#(
    parameter lfsr_t SEED = 16'hACE1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  noise_i,
    output logic  rand_o,
    output lfsr_t state_o
);
    typedef struct packed {
        lfsr_t sr;
    } lfsr_reg_t;

    lfsr_reg_t r_d, r_q;
    logic      fb;

    always_comb begin
        r_d = r_q;
        fb  = (^(r_q.sr & TAP_MASK)) ^ noise_i;
        r_d.sr = {r_q.sr[LFSR_W-2:0], fb};
        if (r_d.sr == '0) begin
            r_d.sr = SEED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sr <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign rand_o  = r_q.sr[0];
    assign state_o = r_q.sr;

    // filler data source must stay alive for varied dummy values
    assert_state_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sr != '0);
endmodule

// File: rtl/rcg_phase.sv
module rcg_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic rand_i,
    output logic core_en_o,
    output logic run_o
);
    typedef struct packed {
        logic phase;
        logic run;
    } phase_reg_t;

    phase_reg_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.phase = r_q.phase ^ rand_i;
        r_d.run   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_en_o = r_q.run & rand_i & ~r_q.phase;
    assign run_o     = r_q.run;

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_en_o |=> !core_en_o);
endmodule

// File: rtl/rcg_counter.sv
module rcg_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (inc_i) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign count_o = r_q.cnt;

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> count_o == $past(count_o) + 1'b1);
    assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(count_o));
endmodule

// File: rtl/rnd_clk_gen.sv
module rnd_clk_gen
    import rcg_pkg::*;
#(
    parameter int    DW   = 8,
    parameter int    CW   = 16,
    parameter lfsr_t SEED = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          noise_i,
    output logic          core_en_o,
    output logic          dummy_o,
    output logic [DW-1:0] dummy_data_o,
    output logic          periph_en_o,
    output logic [CW-1:0] core_count_o
);
    localparam int DSEL = (DW < LFSR_W) ? DW : LFSR_W;

    logic  rnd_bit;
    lfsr_t lfsr_state;
    logic  run;
    logic  core_en;

    rcg_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .noise_i (noise_i),
        .rand_o  (rnd_bit),
        .state_o (lfsr_state)
    );

    rcg_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .rand_i    (rnd_bit),
        .core_en_o (core_en),
        .run_o     (run)
    );

    rcg_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (core_en),
        .count_o (core_count_o)
    );

    always_comb begin
        dummy_data_o = '0;
        if (dummy_o) begin
            dummy_data_o[DSEL-1:0] = lfsr_state[LFSR_W-1 -: DSEL];
        end
    end

    assign core_en_o   = core_en;
    assign dummy_o     = run & ~core_en;
    assign periph_en_o = run;

    assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_en_o && dummy_o));
    assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en_o |-> (core_en_o || dummy_o));
endmodule

// File: tb/sim_rnd_clk_gen.sv
`timescale 1ns/1ps
module sim_rnd_clk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        noise = 1'b0;
    logic        core_en, dummy, periph_en;
    logic [7:0]  ddata;
    logic [15:0] ccount;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rnd_clk_gen u0 (
        .clk(clk), .rst_n(rst_n), .noise_i(noise),
        .core_en_o(core_en), .dummy_o(dummy), .dummy_data_o(ddata),
        .periph_en_o(periph_en), .core_count_o(ccount)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic noise_of(input int mode, input int i);
        if (mode == 0) return 1'b0;
        if (mode == 1) return 1'b1;
        return i[0];
    endfunction

    task automatic do_reset(input logic nz);
        @(negedge clk);
        rst_n = 1'b0;
        noise = nz;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: everything low while reset is held
        check(core_en == 0 && dummy == 0 && periph_en == 0, "R1 enables", {core_en, dummy, periph_en}, 0);
        check(ddata == 0, "R1 data", ddata, 0);
        check(ccount == 0, "R1 count", ccount, 0);
    endtask

    task automatic t_window(input int mode);
        int tally = 0;
        int bad_per = 0, bad_adj = 0, bad_cnt = 0, bad_dum = 0, bad_dat = 0;
        int exp_cnt = 0, act_cnt = 0;
        int first_data = -1;
        bit varied = 0;
        logic prev_en = 1'b0;
        do_reset(noise_of(mode, 0));
        for (int i = 0; i < 1000; i++) begin
            if (periph_en !== 1'b1) bad_per++;                   // R2
            if (prev_en && core_en) bad_adj++;                   // R3
            if (ccount != tally[15:0]) begin                     // R5
                bad_cnt++; exp_cnt = tally; act_cnt = ccount;
            end
            if (dummy !== ~core_en) bad_dum++;                   // R6
            if (!dummy && ddata != 0) bad_dat++;                 // R7
            if (dummy) begin
                if (first_data < 0) first_data = ddata;
                else if (ddata != first_data) varied = 1;
            end
            prev_en = core_en;
            if (core_en) tally++;
            noise = noise_of(mode, i + 1);
            @(negedge clk);
        end
        check(bad_per == 0, "R2 peripheral enable", bad_per, 0);
        check(bad_adj == 0, "R3 adjacent pulses", bad_adj, 0);
        check(tally >= 200 && tally <= 300, "R4 core cycles in 1000", tally, 250);
        check(bad_cnt == 0, "R5 counter", act_cnt, exp_cnt);
        check(bad_dum == 0, "R6 dummy strobe", bad_dum, 0);
        check(bad_dat == 0, "R7 idle data zero", bad_dat, 0);
        check(varied, "R7 data varies", varied, 1);
    endtask

    task automatic record(input logic nz, output logic [63:0] pat);
        do_reset(nz);
        for (int i = 0; i < 64; i++) begin
            pat[i] = core_en;
            @(negedge clk);
        end
    endtask

    task automatic t_noise_mix;
        logic [63:0] p0, p1;
        record(1'b0, p0);
        record(1'b1, p1);
        // R8: noise changes the enable pattern
        check(p0 != p1, "R8 noise mixing", (p0 == p1), 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_window(0);
        t_window(1);
        t_window(2);
        t_noise_mix();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule